// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This block forms the second ALU operand of a 32-bit processor datapath and the carry that the shift step produces. It works in one of two forms. In the shifted-register form a register value is moved by one of four shift kinds. The distance comes either from a short immediate field or from the low byte of another register. In the rotated-constant form a byte constant is widened to the datapath width and rotated right by an even distance taken from a small rotate field.

The current carry flag is an input. Some zero-distance encodings keep it, one encoding moves it into the top bit of the result, and the rotated-constant form keeps it when the rotate is zero. Decode, ALU arithmetic and flag writeback sit outside this block. It takes the fields it needs and hands back the operand and carry. Both results are registered, so they appear one clock after the inputs are presented.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `carry_out` become zero at that edge. Otherwise both outputs show the value computed from the inputs present at the previous rising edge.
- R2: Shift kind 0 is logical left. For a distance n from 1 to 31 the vacated low bits fill with zeros, and `carry_out` is bit 32-n of the input value.
- R3: Shift kind 1 is logical right. For n from 1 to 31 the vacated high bits fill with zeros, and `carry_out` is bit n-1 of the input value.
- R4: Shift kind 2 is arithmetic right. For n from 1 to 31 the vacated high bits copy bit 31 of the input value, and `carry_out` is bit n-1 of the input value.
- R5: Shift kind 3 is rotate right. For n from 1 to 31, bits leaving at the bottom re-enter at the top, and `carry_out` equals bit 31 of the result.
- R6: When `amt_src` is 0, the distance is the 5-bit `amt_imm`. If that field is zero, logical left passes the value through with `carry_out` equal to `carry_in`, and logical right and arithmetic right act as a distance of 32.
- R7: When `amt_src` is 0, `amt_imm` is 0 and the kind is rotate right, the result is `carry_in` above bits 31..1 of the value, and `carry_out` is bit 0 of the value.
- R8: When `amt_src` is 1, the distance is bits 7..0 of `amt_reg`, and bits 31..8 have no effect. A distance of zero passes the value through and sets `carry_out` to `carry_in` for every kind.
- R9: For a register distance of 32 or more, logical left and logical right give zero. At exactly 32 their carry is bit 0 (left) or bit 31 (right). Above 32 the carry is 0. Arithmetic right gives 32 copies of bit 31 and a carry equal to bit 31.
- R10: For a register distance of 32 or more, rotate right uses the distance modulo 32. When that remainder is zero, the value is unchanged and `carry_out` is bit 31.
- R11: When `imm_mode` is 1, the result is `imm_byte` zero-extended and rotated right by twice `imm_rot`, and all shifted-register inputs are ignored. The carry is `carry_in` when `imm_rot` is 0 and bit 31 of the result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_src | input | 1 | 0 takes the distance from amt_imm, 1 from amt_reg |
| amt_imm | input | 5 | Immediate shift distance |
| amt_reg | input | 32 | Register holding the distance in its low byte |
| imm_mode | input | 1 | 1 selects the rotated-constant form |
| imm_byte | input | 8 | Constant for the rotated-constant form |
| imm_rot | input | 4 | Half of the right-rotate distance for the constant |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand, registered |
| carry_out | output | 1 | Shifter carry, registered |

## Verification
Every result depends only on the inputs sampled at one rising edge and shows up right after that edge. The operand and the carry are both due exactly one cycle after their stimulus. The bench changes inputs on the falling edge, lets one rising edge pass, and reads both outputs on the next falling edge. Each vector therefore finds its own result and never the one before it. The bound checker relates the outputs at each edge to the inputs one edge earlier, and only after a cycle that was out of reset.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  // Special-case controls produced by the distance decoder
  typedef struct packed {
    logic rrx;   // one-bit rotate through the carry flag
    logic pass;  // value and carry go through untouched
  } sh_ctl_t;

endpackage

// File: rtl/opsh_amount.sv
// Picks the effective shift distance and marks the zero-distance special cases.
module opsh_amount
  import opsh_pkg::*;
#(
  parameter int W         = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5
) (
  input  sh_kind_e             kind,
  input  logic                 amt_src,
  input  logic [IMM_AMT_W-1:0] amt_imm,
  input  logic [W-1:0]         amt_reg,
  output logic [AMT_W-1:0]     amt,
  output sh_ctl_t              ctl
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^amt_reg[W-1:AMT_W];

  always_comb begin
    amt = '0;
    ctl = '0;
    if (amt_src) begin
      amt      = amt_reg[AMT_W-1:0];
      ctl.pass = (amt_reg[AMT_W-1:0] == '0);
    end else if (amt_imm == '0) begin
      unique case (kind)
        SH_LSL:  ctl.pass = 1'b1;
        SH_ROR:  ctl.rrx  = 1'b1;
        default: amt      = AMT_W'(W);
      endcase
    end else begin
      amt = AMT_W'(amt_imm);
    end
  end

endmodule

// File: rtl/opsh_core.sv
// Shifts a register value by a decoded distance and returns the last bit out.
module opsh_core
  import opsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     val,
  input  sh_kind_e         kind,
  input  logic [AMT_W-1:0] amt,
  input  sh_ctl_t          ctl,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);

  localparam int SH_W = $clog2(W);

  logic [W:0]       lsl_w;
  logic [W:0]       lsr_w;
  logic [W:0]       asr_w;
  logic [2*W-1:0]   ror_w;
  logic [AMT_W-1:0] asr_amt;

  // One guard bit beside the value catches the last bit shifted out
  assign lsl_w   = {1'b0, val} << amt;
  assign lsr_w   = {val, 1'b0} >> amt;
  assign asr_amt = (int'(amt) > W) ? AMT_W'(W) : amt;
  assign asr_w   = (W+1)'($signed({val, 1'b0}) >>> asr_amt);
  assign ror_w   = {val, val} >> amt[SH_W-1:0];

  always_comb begin
    res  = val;
    cout = cin;
    if (ctl.pass) begin
      res  = val;
      cout = cin;
    end else if (ctl.rrx) begin
      res  = {cin, val[W-1:1]};
      cout = val[0];
    end else begin
      unique case (kind)
        SH_LSL: begin
          res  = lsl_w[W-1:0];
          cout = lsl_w[W];
        end
        SH_LSR: begin
          res  = lsr_w[W:1];
          cout = lsr_w[0];
        end
        SH_ASR: begin
          res  = asr_w[W:1];
          cout = asr_w[0];
        end
        default: begin
          res  = ror_w[W-1:0];
          cout = ror_w[W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/opsh_immrot.sv
// Rotated-constant form: widens a byte and rotates it right by 2*rot.
module opsh_immrot #(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);

  logic [W-1:0] stage [ROT_W+1];

  assign stage[0] = W'(imm);

  // One fixed rotate per rotate-field bit; stage k moves by 2 << k
  for (genvar k = 0; k < ROT_W; k++) begin : g_stage
    localparam int DIST = 2 << k;
    assign stage[k+1] = rot[k] ? {stage[k][DIST-1:0], stage[k][W-1:DIST]}
                               : stage[k];
  end

  assign res  = stage[ROT_W];
  assign cout = (rot == '0) ? cin : stage[ROT_W][W-1];

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opsh_pkg::*;
#(
  parameter int W         = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         opnd_val,
  input  logic [1:0]           shift_kind,
  input  logic                 amt_src,
  input  logic [IMM_AMT_W-1:0] amt_imm,
  input  logic [W-1:0]         amt_reg,
  input  logic                 imm_mode,
  input  logic [IMM_W-1:0]     imm_byte,
  input  logic [ROT_W-1:0]     imm_rot,
  input  logic                 carry_in,
  output logic [W-1:0]         result,
  output logic                 carry_out
);

  sh_kind_e         kind;
  logic [AMT_W-1:0] eff_amt;
  sh_ctl_t          ctl;
  logic [W-1:0]     sh_res;
  logic             sh_c;
  logic [W-1:0]     ir_res;
  logic             ir_c;

  assign kind = sh_kind_e'(shift_kind);

  opsh_amount #(.W(W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W)) u_amt (
    .kind    (kind),
    .amt_src (amt_src),
    .amt_imm (amt_imm),
    .amt_reg (amt_reg),
    .amt     (eff_amt),
    .ctl     (ctl)
  );

  opsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .val  (opnd_val),
    .kind (kind),
    .amt  (eff_amt),
    .ctl  (ctl),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_c)
  );

  opsh_immrot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_irot (
    .imm  (imm_byte),
    .rot  (imm_rot),
    .cin  (carry_in),
    .res  (ir_res),
    .cout (ir_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else if (imm_mode) begin
      result    <= ir_res;
      carry_out <= ir_c;
    end else begin
      result    <= sh_res;
      carry_out <= sh_c;
    end
  end

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int W         = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         opnd_val,
  input logic [1:0]           shift_kind,
  input logic                 amt_src,
  input logic [IMM_AMT_W-1:0] amt_imm,
  input logic [W-1:0]         amt_reg,
  input logic                 imm_mode,
  input logic [IMM_W-1:0]     imm_byte,
  input logic [ROT_W-1:0]     imm_rot,
  input logic                 carry_in,
  input logic [W-1:0]         result,
  input logic                 carry_out
);

  logic rst_q;
  logic armed;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    armed <= !rst;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      rst_clear_chk: assert (result == '0 && !carry_out);
    end
  end

  // R8
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!imm_mode && amt_src && amt_reg[AMT_W-1:0] == '0)
    |-> result == $past(opnd_val) && carry_out == $past(carry_in));

  // R7
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!imm_mode && !amt_src && amt_imm == '0 && shift_kind == 2'd3)
    |-> result == {$past(carry_in), $past(opnd_val[W-1:1])}
        && carry_out == $past(opnd_val[0]));

  // R9
  lsr_far_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!imm_mode && amt_src && shift_kind == 2'd1
                   && int'(amt_reg[AMT_W-1:0]) > W)
    |-> result == '0 && !carry_out);

  // R11
  imm_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(imm_mode)
    |-> $countones(result) == $countones($past(imm_byte)));

  // R11
  imm_norot_carry_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(imm_mode && imm_rot == '0)
    |-> carry_out == $past(carry_in) && result == W'($past(imm_byte)));

endmodule

bind opnd_shifter opnd_shifter_chk #(
  .W(W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (.*);

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opnd_val;
  logic [1:0]  shift_kind;
  logic        amt_src;
  logic [4:0]  amt_imm;
  logic [31:0] amt_reg;
  logic        imm_mode;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  opnd_shifter u0 (
    .clk(clk), .rst(rst), .opnd_val(opnd_val), .shift_kind(shift_kind),
    .amt_src(amt_src), .amt_imm(amt_imm), .amt_reg(amt_reg),
    .imm_mode(imm_mode), .imm_byte(imm_byte), .imm_rot(imm_rot),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  // Bit-by-bit model written from the requirements; {carry, value}
  function automatic logic [32:0] model(
    input logic [31:0] v, input logic [1:0] k, input logic src,
    input logic [4:0] ai, input logic [31:0] ar, input logic im,
    input logic [7:0] b, input logic [3:0] r, input logic ci);
    logic [31:0] o;
    logic        c;
    int          n;
    int          m;
    o = '0;
    c = ci;
    if (im) begin
      for (int i = 0; i < 32; i++)
        o[i] = (((i + 2 * r) % 32) < 8) ? b[(i + 2 * r) % 32] : 1'b0;
      c = (r == 0) ? ci : o[31];
      return {c, o};
    end
    n = src ? int'(ar[7:0]) : int'(ai);
    if (n == 0) begin
      if (src || k == 2'd0) return {ci, v};
      if (k == 2'd3) return {v[0], ci, v[31:1]};
      n = 32;
    end
    case (k)
      2'd0: begin
        for (int i = 0; i < 32; i++) o[i] = (i - n >= 0) ? v[i - n] : 1'b0;
        c = (n <= 32) ? v[32 - n] : 1'b0;
      end
      2'd1: begin
        for (int i = 0; i < 32; i++) o[i] = (i + n < 32) ? v[i + n] : 1'b0;
        c = (n <= 32) ? v[n - 1] : 1'b0;
      end
      2'd2: begin
        for (int i = 0; i < 32; i++) o[i] = (i + n < 32) ? v[i + n] : v[31];
        c = (n <= 32) ? v[n - 1] : v[31];
      end
      default: begin
        m = n % 32;
        for (int i = 0; i < 32; i++) o[i] = v[(i + m) % 32];
        c = o[31];
      end
    endcase
    return {c, o};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] er, input logic ec);
    n_chk++;
    if (result !== er || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
               tag, result, carry_out, er, ec);
    end
  endtask

  // Inputs change on a falling edge; result is read one full cycle later
  task automatic apply(input string tag, input logic [31:0] v, input logic [1:0] k,
                       input logic src, input logic [4:0] ai, input logic [31:0] ar,
                       input logic im, input logic [7:0] b, input logic [3:0] r,
                       input logic ci);
    logic [32:0] e;
    opnd_val = v; shift_kind = k; amt_src = src; amt_imm = ai; amt_reg = ar;
    imm_mode = im; imm_byte = b; imm_rot = r; carry_in = ci;
    e = model(v, k, src, ai, ar, im, b, r, ci);
    @(posedge clk);
    @(negedge clk);
    cmp(tag, e[31:0], e[32]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    opnd_val = 32'hFFFF_FFFF; shift_kind = 2'd0; amt_src = 1'b0;
    amt_imm = 5'd0; amt_reg = '0; imm_mode = 1'b0; imm_byte = '0;
    imm_rot = '0; carry_in = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp("R1 reset", 32'h0, 1'b0);
    rst = 1'b0;
    apply("R1 first", 32'h1234_5678, 2'd0, 1'b0, 5'd4, '0, 1'b0, 8'h0, 4'h0, 1'b0);
    cmp("R1 latency", 32'h2345_6780, 1'b1);
  endtask

  task automatic t_lsl;
    apply("R2 lsl1",  32'h8000_0001, 2'd0, 1'b0, 5'd1,  '0, 1'b0, 0, 0, 1'b0);
    apply("R2 lsl31", 32'h0000_0003, 2'd0, 1'b0, 5'd31, '0, 1'b0, 0, 0, 1'b0);
    apply("R2 lslr",  32'hA5A5_F00F, 2'd0, 1'b1, 5'd0,  32'd12, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_lsr;
    apply("R3 lsr1",  32'h0000_0001, 2'd1, 1'b0, 5'd1,  '0, 1'b0, 0, 0, 1'b0);
    apply("R3 lsr31", 32'hC000_0000, 2'd1, 1'b0, 5'd31, '0, 1'b0, 0, 0, 1'b1);
    apply("R3 lsrr",  32'hDEAD_BEEF, 2'd1, 1'b1, 5'd0,  32'd7, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_asr;
    apply("R4 asrneg", 32'h8000_00F0, 2'd2, 1'b0, 5'd5,  '0, 1'b0, 0, 0, 1'b0);
    apply("R4 asrpos", 32'h7FFF_0001, 2'd2, 1'b0, 5'd16, '0, 1'b0, 0, 0, 1'b1);
    apply("R4 asr31",  32'h8000_0000, 2'd2, 1'b1, 5'd0,  32'd31, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_ror;
    apply("R5 ror4",  32'h1234_5678, 2'd3, 1'b0, 5'd4,  '0, 1'b0, 0, 0, 1'b0);
    apply("R5 ror1",  32'h0000_0001, 2'd3, 1'b0, 5'd1,  '0, 1'b0, 0, 0, 1'b0);
    apply("R5 ror31", 32'h8000_0000, 2'd3, 1'b1, 5'd0,  32'd31, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_imm_zero;
    apply("R6 lsl0",  32'hCAFE_F00D, 2'd0, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b1);
    apply("R6 lsl0c", 32'hCAFE_F00D, 2'd0, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b0);
    apply("R6 lsr0",  32'h8000_0000, 2'd1, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b0);
    apply("R6 asr0",  32'h8000_0000, 2'd2, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b0);
    apply("R6 asr0p", 32'h7000_0000, 2'd2, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_rrx;
    apply("R7 rrx1", 32'h0000_0003, 2'd3, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b1);
    apply("R7 rrx0", 32'hFFFF_FFFE, 2'd3, 1'b0, 5'd0, '0, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_reg_byte;
    apply("R8 hiign",  32'h0F0F_0F0F, 2'd0, 1'b1, 5'd0,  32'hFFFF_FF04, 1'b0, 0, 0, 1'b0);
    apply("R8 zlsr",   32'h8765_4321, 2'd1, 1'b1, 5'd9,  32'hABCD_EF00, 1'b0, 0, 0, 1'b1);
    apply("R8 zror",   32'h8765_4321, 2'd3, 1'b1, 5'd0,  32'h0000_0100, 1'b0, 0, 0, 1'b0);
    apply("R8 zasr",   32'h8765_4321, 2'd2, 1'b1, 5'd3,  32'h0000_0000, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_reg_large;
    apply("R9 lsl32",  32'h0000_0001, 2'd0, 1'b1, 5'd0, 32'd32,  1'b0, 0, 0, 1'b0);
    apply("R9 lsl33",  32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 32'd33,  1'b0, 0, 0, 1'b1);
    apply("R9 lsr32",  32'h8000_0000, 2'd1, 1'b1, 5'd0, 32'd32,  1'b0, 0, 0, 1'b0);
    apply("R9 lsr200", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 32'd200, 1'b0, 0, 0, 1'b1);
    apply("R9 asr255", 32'h9000_0000, 2'd2, 1'b1, 5'd0, 32'd255, 1'b0, 0, 0, 1'b0);
    apply("R9 asr40p", 32'h6000_0000, 2'd2, 1'b1, 5'd0, 32'd40,  1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_ror_mod;
    apply("R10 ror36", 32'h1234_5678, 2'd3, 1'b1, 5'd0, 32'd36, 1'b0, 0, 0, 1'b0);
    apply("R10 ror64", 32'h8000_0001, 2'd3, 1'b1, 5'd0, 32'd64, 1'b0, 0, 0, 1'b0);
    apply("R10 ror32", 32'h7FFF_FFFF, 2'd3, 1'b1, 5'd0, 32'd32, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_immform;
    apply("R11 rot0",  32'hFFFF_FFFF, 2'd0, 1'b1, 5'd3, 32'd8, 1'b1, 8'hFF, 4'd0, 1'b1);
    apply("R11 rot1",  32'h0,         2'd3, 1'b0, 5'd0, 32'd0, 1'b1, 8'h03, 4'd1, 1'b0);
    apply("R11 rot4",  32'h0,         2'd1, 1'b0, 5'd7, 32'd0, 1'b1, 8'hAB, 4'd4, 1'b1);
    apply("R11 rot15", 32'h0,         2'd2, 1'b0, 5'd1, 32'd0, 1'b1, 8'h81, 4'd15, 1'b0);
    apply("R11 rot12", 32'h0,         2'd0, 1'b0, 5'd0, 32'd0, 1'b1, 8'h7F, 4'd12, 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_imm_zero();
    t_rrx();
    t_reg_byte();
    t_reg_large();
    t_ror_mod();
    t_immform();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no end of run, expected one before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule